// File: doc/BRIEF.md
# Dual-Master Bus Ownership Selector

This block decides which of two upstream controllers owns a single shared downstream two-wire bus. It treats the pass switches as logical open-drain routing. The downstream line level is the wired-AND of the downstream devices, the connected upstream controller and the internal recovery driver. An unconnected upstream side sees only its own lines. Each controller asks for ownership through its own write strobe. Either one can take the bus at any moment, and the current owner has no say.

Each controller has one active-low interrupt line, and four sources share it. The first forwards the downstream interrupt input. The second flags that ownership was taken away. The third flags that a bus recovery sequence has finished. The fourth warns that a switch happened while the downstream bus was busy, which tells the new owner to recover the bus itself. A small sensor follows START and STOP conditions so the block knows when the bus is busy. When recovery is enabled, a switch first disconnects both sides. The block then clocks out nine SCL pulses with SDA released and a STOP, and only after that connects the new owner.

Top module: `bus_owner_sel`

## Requirements
- R1: At most one of `sw_en[1:0]` is high at any time; `own_vld` is high exactly when one bit is high, and `own_id` names that channel.
- R2: After reset with `RST_CH0=0`, no channel is connected and both `int_n` are high. With `RST_CH0=1`, channel 0 is connected. Reset clears every pending interrupt.
- R3: A write with `wr_stb[m]` high and data bit 0 set is a take request from controller m. A take request from a non-owner moves ownership at the next clock edge. A take request from the current owner changes nothing.
- R4: When both controllers request in the same cycle, the most recently granted one loses. Before any grant in the `RST_CH0=0` variant, channel 0 wins.
- R5: When ownership leaves a controller, its lost flag (source 1) is set.
- R6: With `rec_en=0`, a switch made while the sensor reports the bus busy sets the unsafe flag (source 3) of the new owner. A switch made on an idle bus does not set it.
- R7: Source 0 is the live, unlatched level of the synchronized active-low `dint_n`, presented to both controllers.
- R8: Sources 1 to 3 are sticky. Each clears only on a write by its own controller with data bit k set, where k is the source number. Mask bit k set keeps source k off `int_n`, and the flag stays pending underneath. `int_n[m]` is low when any unmasked source of controller m is set.
- R9: With `rec_en=1`, a switch disconnects both channels for 21×`REC_HALF` cycles. During that time the bus carries nine SCL high pulses with SDA released, then SDA low, then SCL high, then SDA high. The new owner is connected next and its done flag (source 2) is set.
- R10: The sensor marks the bus busy after SDA falls while SCL is high, and idle after SDA rises while SCL is high.
- R11: The bus lines are the AND of the downstream inputs, the connected controller's lines and the recovery driver. Only the connected controller sees the bus on `up_scl_o`/`up_sda_o`, and the other reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_stb | input | 2 | Per-controller register write strobe |
| wr_dat0 | input | 4 | Controller 0 write data: bit0 take, bits 3:1 clear flags |
| wr_dat1 | input | 4 | Controller 1 write data: bit0 take, bits 3:1 clear flags |
| mask0 | input | 4 | Controller 0 source masks (1 = masked) |
| mask1 | input | 4 | Controller 1 source masks (1 = masked) |
| rec_en | input | 1 | Enable recovery sequence on switch |
| dint_n | input | 1 | Downstream interrupt, active low |
| up_scl_i | input | 2 | Upstream SCL levels driven by each controller |
| up_sda_i | input | 2 | Upstream SDA levels driven by each controller |
| dn_scl_i | input | 1 | Downstream SCL pull-down level |
| dn_sda_i | input | 1 | Downstream SDA pull-down level |
| bus_scl_o | output | 1 | Resolved downstream SCL |
| bus_sda_o | output | 1 | Resolved downstream SDA |
| up_scl_o | output | 2 | SCL seen by each controller |
| up_sda_o | output | 2 | SDA seen by each controller |
| int_n | output | 2 | Per-controller interrupt, active low |
| own_vld | output | 1 | A channel is connected |
| own_id | output | 1 | Connected channel |
| sw_en | output | 2 | Switch enables per channel |

## Verification
The assertions assume that reset is held for at least one clock edge and that requests arrive only as single-cycle write strobes. They also assume that line inputs change away from the clock edge, so the two-flop synchronizers see clean levels. The stimulus drives every input on the falling edge. It lowers SCL before it lowers SDA whenever a routing test must not look like a START. It creates bus traffic only where a busy-bus switch is intended. No request is issued while a recovery sequence is running.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LINK, ST_REC} own_st_e;

    typedef struct packed {
        own_st_e st;
        logic    own;
        logic    last;
        logic    tgt;
    } ctl_s;

    localparam int NCH   = 2;
    localparam int NSRC  = 4;
    localparam int NSTK  = NSRC - 1;
    localparam int NSTEP = 21;
endpackage

// File: rtl/bsel_sense.sv
module bsel_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy_o
);
    typedef struct packed {
        logic [1:0] scl;
        logic [1:0] sda;
        logic       sda_p;
        logic       busy;
    } sn_s;

    sn_s  s_d, s_q;
    logic start, stop;

    assign start = s_q.sda_p & ~s_q.sda[1] & s_q.scl[1];
    assign stop  = ~s_q.sda_p & s_q.sda[1] & s_q.scl[1];

    always_comb begin
        s_d       = s_q;
        s_d.scl   = {s_q.scl[0], scl_i};
        s_d.sda   = {s_q.sda[0], sda_i};
        s_d.sda_p = s_q.sda[1];
        if (start)     s_d.busy = 1'b1;
        else if (stop) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{scl: 2'b11, sda: 2'b11, sda_p: 1'b1, busy: 1'b0};
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_o);  // R10
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !busy_o);  // R10
endmodule

// File: rtl/bsel_recov.sv
module bsel_recov #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic act_o,
    output logic done_o,
    output logic scl_o,
    output logic sda_o
);
    import bsel_pkg::*;
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HC_END = HW'(HALF - 1);
    localparam logic [4:0] STEP_END  = 5'(NSTEP - 1);
    localparam logic [4:0] STEP_NACK = 5'(NSTEP - 3);

    typedef struct packed {
        logic          act;
        logic [4:0]    step;
        logic [HW-1:0] hc;
    } rc_s;

    rc_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (go_i) begin
            r_d.act  = 1'b1;
            r_d.step = '0;
            r_d.hc   = '0;
        end else if (r_q.act) begin
            if (r_q.hc == HC_END) begin
                r_d.hc = '0;
                if (r_q.step == STEP_END) r_d.act = 1'b0;
                else                      r_d.step = r_q.step + 5'd1;
            end else begin
                r_d.hc = r_q.hc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign act_o  = r_q.act;
    assign done_o = r_q.act && r_q.step == STEP_END && r_q.hc == HC_END;
    assign scl_o  = !r_q.act || ((r_q.step < STEP_NACK) ? r_q.step[0] : (r_q.step != STEP_NACK));
    assign sda_o  = !r_q.act || (r_q.step < STEP_NACK) || (r_q.step == STEP_END);

    AST_REC_NO_REGO: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.act |-> !go_i);  // R9
endmodule

// File: rtl/bsel_irq.sv
module bsel_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] set_i,
    input  logic       clr_stb_i,
    input  logic [2:0] clr_i,
    input  logic       fwd_i,
    input  logic [3:0] mask_i,
    output logic [2:0] stk_o,
    output logic       int_n_o
);
    logic [2:0] stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (clr_stb_i) stk_d = stk_d & ~clr_i;
        stk_d = stk_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign stk_o   = stk_q;
    assign int_n_o = ~|({stk_q, fwd_i} & ~mask_i);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb_i |=> ((stk_q & $past(stk_q)) == $past(stk_q)));  // R8
endmodule

// File: rtl/bus_owner_sel.sv
module bus_owner_sel #(
    parameter bit RST_CH0  = 1'b0,
    parameter int REC_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] wr_stb,
    input  logic [3:0] wr_dat0,
    input  logic [3:0] wr_dat1,
    input  logic [3:0] mask0,
    input  logic [3:0] mask1,
    input  logic       rec_en,
    input  logic       dint_n,
    input  logic [1:0] up_scl_i,
    input  logic [1:0] up_sda_i,
    input  logic       dn_scl_i,
    input  logic       dn_sda_i,
    output logic       bus_scl_o,
    output logic       bus_sda_o,
    output logic [1:0] up_scl_o,
    output logic [1:0] up_sda_o,
    output logic [1:0] int_n,
    output logic       own_vld,
    output logic       own_id,
    output logic [1:0] sw_en
);
    import bsel_pkg::*;

    localparam ctl_s CTL_RST = RST_CH0 ? '{st: ST_LINK, own: 1'b0, last: 1'b0, tgt: 1'b0}
                                       : '{st: ST_IDLE, own: 1'b0, last: 1'b1, tgt: 1'b0};

    ctl_s       c_d, c_q;
    logic [1:0] dint_q;
    logic [1:0] req;
    logic       pick, busy;
    logic [1:0] lost_set, done_set, uns_set;
    logic       rec_go, rec_act, rec_done, rec_scl, rec_sda;
    logic [NCH-1:0][NSTK-1:0] stk;

    assign req  = {wr_stb[1] & wr_dat1[0], wr_stb[0] & wr_dat0[0]};
    assign pick = (&req) ? ~c_q.last : req[1];

    always_comb begin
        c_d      = c_q;
        lost_set = '0;
        done_set = '0;
        uns_set  = '0;
        rec_go   = 1'b0;
        case (c_q.st)
            ST_IDLE, ST_LINK: begin
                if (|req && !(c_q.st == ST_LINK && pick == c_q.own)) begin
                    if (c_q.st == ST_LINK) lost_set[c_q.own] = 1'b1;
                    c_d.last = pick;
                    c_d.tgt  = pick;
                    if (rec_en) begin
                        c_d.st = ST_REC;
                        rec_go = 1'b1;
                    end else begin
                        c_d.st        = ST_LINK;
                        c_d.own       = pick;
                        uns_set[pick] = busy;
                    end
                end
            end
            ST_REC: begin
                if (|req) begin
                    c_d.tgt  = pick;
                    c_d.last = pick;
                end
                if (rec_done) begin
                    c_d.st             = ST_LINK;
                    c_d.own            = c_d.tgt;
                    done_set[c_d.tgt]  = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= CTL_RST;
            dint_q <= 2'b11;
        end else begin
            c_q    <= c_d;
            dint_q <= {dint_q[0], dint_n};
        end
    end

    assign own_vld = (c_q.st == ST_LINK);
    assign own_id  = c_q.own;
    assign sw_en   = {own_vld & c_q.own, own_vld & ~c_q.own};

    assign bus_scl_o = dn_scl_i & rec_scl & (~sw_en[0] | up_scl_i[0]) & (~sw_en[1] | up_scl_i[1]);
    assign bus_sda_o = dn_sda_i & rec_sda & (~sw_en[0] | up_sda_i[0]) & (~sw_en[1] | up_sda_i[1]);

    bsel_sense i_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(bus_scl_o), .sda_i(bus_sda_o), .busy_o(busy)
    );

    bsel_recov #(.HALF(REC_HALF)) i_recov (
        .clk(clk), .rst_n(rst_n), .go_i(rec_go), .act_o(rec_act),
        .done_o(rec_done), .scl_o(rec_scl), .sda_o(rec_sda)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [3:0] wd;
        logic [3:0] mk;
        assign wd = (g == 0) ? wr_dat0 : wr_dat1;
        assign mk = (g == 0) ? mask0 : mask1;
        assign up_scl_o[g] = sw_en[g] ? bus_scl_o : 1'b1;
        assign up_sda_o[g] = sw_en[g] ? bus_sda_o : 1'b1;

        bsel_irq i_irq (
            .clk(clk), .rst_n(rst_n),
            .set_i({uns_set[g], done_set[g], lost_set[g]}),
            .clr_stb_i(wr_stb[g]), .clr_i(wd[3:1]),
            .fwd_i(~dint_q[1]), .mask_i(mk),
            .stk_o(stk[g]), .int_n_o(int_n[g])
        );
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_en) <= 1 && (own_vld == |sw_en));  // R1
    AST_LOST_NOTICE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(own_vld) && !(own_vld && own_id == $past(own_id))) |-> stk[$past(own_id)][0]);  // R5
    AST_UNSAFE_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (own_vld && (!$past(own_vld) || own_id != $past(own_id)) && $past(busy)
         && !$past(rec_en) && $past(c_q.st) != ST_REC) |-> stk[own_id][2]);  // R6
    AST_REC_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_act |-> sw_en == 2'b00);  // R9
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask0) |-> int_n[0]);  // R8
endmodule

// File: tb/test_bus_owner_sel.sv
module test_bus_owner_sel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wr_stb = '0;
    logic [3:0] wr_dat0 = '0, wr_dat1 = '0, mask0 = '0, mask1 = '0;
    logic       rec_en = 1'b0, dint_n = 1'b1;
    logic [1:0] up_scl_i = 2'b11, up_sda_i = 2'b11;
    logic       dn_scl_i = 1'b1, dn_sda_i = 1'b1;
    logic       bus_scl_o, bus_sda_o, own_vld, own_id;
    logic [1:0] up_scl_o, up_sda_o, int_n, sw_en;
    logic       a_scl, a_sda, a_vld, a_id;
    logic [1:0] a_uscl, a_usda, a_int, a_sw;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bus_owner_sel #(.RST_CH0(1'b0), .REC_HALF(2)) i_bus_owner_sel (
        .clk, .rst_n, .wr_stb, .wr_dat0, .wr_dat1, .mask0, .mask1, .rec_en, .dint_n,
        .up_scl_i, .up_sda_i, .dn_scl_i, .dn_sda_i, .bus_scl_o, .bus_sda_o,
        .up_scl_o, .up_sda_o, .int_n, .own_vld, .own_id, .sw_en);

    bus_owner_sel #(.RST_CH0(1'b1), .REC_HALF(2)) i_alt (
        .clk, .rst_n, .wr_stb, .wr_dat0, .wr_dat1, .mask0, .mask1, .rec_en, .dint_n,
        .up_scl_i, .up_sda_i, .dn_scl_i, .dn_sda_i, .bus_scl_o(a_scl), .bus_sda_o(a_sda),
        .up_scl_o(a_uscl), .up_sda_o(a_usda), .int_n(a_int), .own_vld(a_vld),
        .own_id(a_id), .sw_en(a_sw));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int m, input logic [3:0] d);
        if (m == 0) begin wr_stb[0] = 1'b1; wr_dat0 = d; end
        else        begin wr_stb[1] = 1'b1; wr_dat1 = d; end
        @(negedge clk);
        wr_stb = '0;
    endtask

    initial begin
        #1600000;
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, rises, swbad;
        logic prev, sda_low;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R2 reset state, both variants
        chk("R2 own_vld", own_vld, 0);
        chk("R2 sw_en", sw_en, 0);
        chk("R2 int_n", int_n, 3);
        chk("R2 alt own_vld", a_vld, 1);
        chk("R2 alt sw_en", a_sw, 1);
        chk("R2 alt int_n", a_int, 3);
        // R11 nothing connected
        up_scl_i[0] = 1'b0; cyc(1);
        chk("R11 isolated scl", bus_scl_o, 1);
        chk("R11 isolated up view", up_scl_o[0], 1);
        up_scl_i[0] = 1'b1; cyc(1);
        // R3 take on idle bus, R6 no warning
        wr(0, 4'b0001);
        chk("R3 own after take", {own_vld, own_id}, 2);
        chk("R1 sw_en ch0", sw_en, 1);
        chk("R6 idle switch no warn", int_n, 3);
        // R11 routing
        up_scl_i[1] = 1'b0; cyc(1);
        chk("R11 non-owner scl ignored", bus_scl_o, 1);
        up_scl_i[1] = 1'b1; up_scl_i[0] = 1'b0; cyc(1);
        chk("R11 owner scl", bus_scl_o, 0);
        chk("R11 other view", up_scl_o[1], 1);
        up_sda_i[0] = 1'b0; cyc(1);
        chk("R11 owner sda", {bus_sda_o, up_sda_o}, 2);
        up_sda_i[0] = 1'b1; cyc(1);
        up_scl_i[0] = 1'b1; cyc(1);
        dn_scl_i = 1'b0; cyc(1);
        chk("R11 downstream scl", {bus_scl_o, up_scl_o}, 2);
        dn_scl_i = 1'b1; cyc(2);
        // R10 START then switch: R5 + R6
        up_sda_i[0] = 1'b0; cyc(5);
        wr(1, 4'b0001);
        chk("R3 takeover", {own_vld, own_id}, 3);
        chk("R5 R6 both flagged", int_n, 0);
        up_sda_i[0] = 1'b1; cyc(6);
        chk("R8 sticky", int_n, 0);
        wr(1, 4'b1000);
        chk("R8 clear unsafe", int_n[1], 1);
        chk("R8 lost still set", int_n[0], 0);
        wr(0, 4'b0010);
        chk("R8 clear lost", int_n[0], 1);
        chk("R8 clear not take", own_id, 1);
        // R3 owner re-request
        wr(1, 4'b0001);
        chk("R3 owner rerequest", {own_vld, own_id, int_n}, 15);
        // R8 mask; R6 idle switch after STOP
        mask1[1] = 1'b1; cyc(1);
        wr(0, 4'b0001);
        chk("R3 take back", own_id, 0);
        chk("R8 masked lost", int_n, 3);
        mask1[1] = 1'b0; cyc(1);
        chk("R8 pending under mask", int_n, 1);
        wr(1, 4'b0010);
        chk("R8 cleared", int_n, 3);
        // R7 forwarding
        dint_n = 1'b0; cyc(3);
        chk("R7 forward both", int_n, 0);
        mask1[0] = 1'b1; cyc(1);
        chk("R7 forward masked", int_n, 2);
        dint_n = 1'b1; cyc(3);
        chk("R7 level not latched", int_n, 3);
        mask1[0] = 1'b0;
        // R4 tie: last grant was 0
        wr_stb = 2'b11; wr_dat0 = 4'b0001; wr_dat1 = 4'b0001;
        cyc(1); wr_stb = '0;
        chk("R4 tie to ch1", own_id, 1);
        chk("R5 lost ch0", int_n, 2);
        wr(0, 4'b0010);
        wr_stb = 2'b11; wr_dat0 = 4'b0001; wr_dat1 = 4'b0001;
        cyc(1); wr_stb = '0;
        chk("R4 tie to ch0", own_id, 0);
        chk("R5 lost ch1", int_n, 1);
        wr(1, 4'b0010);
        // R9 recovery
        rec_en = 1'b1;
        prev = 1'b1; n = 0; rises = 0; swbad = 0; sda_low = 1'b0;
        wr(1, 4'b0001);
        while (!own_vld && n < 500) begin
            n++;
            if (bus_scl_o && !prev) rises++;
            if (!bus_sda_o) sda_low = 1'b1;
            if (sw_en != 2'b00) swbad++;
            prev = bus_scl_o;
            @(negedge clk);
        end
        chk("R9 duration", n, 42);
        chk("R9 scl rises", rises, 10);
        chk("R9 stop seen", {sda_low, bus_sda_o, bus_scl_o}, 7);
        chk("R9 isolated", swbad, 0);
        chk("R9 owner", {own_vld, own_id}, 3);
        chk("R9 R5 flags", int_n, 0);
        wr(1, 4'b0100);
        wr(0, 4'b0010);
        chk("R9 done cleared", int_n, 3);
        rec_en = 1'b0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule